// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block forms the trigger signal that a master timer sends to its slave timers. A three-bit mode input picks one of five internal events or levels, and the chosen one is registered before it leaves the block. The sources are the software update-generate strobe, the counter-enable signal, the update event, a per-match pulse from the channel 1 capture/compare logic, and the channel 1 output reference level. Mode codes beyond the five defined ones hold the trigger low.

The block also builds the counter-enable signal. It combines the software enable bit with the slave trigger input, and the trigger input counts only while gated mode is active. The result is both a trigger source and a port of its own, so the counter can use it. The counter, the compare unit and the slave controller sit outside the block, and their signals arrive as primary inputs.

Top module: `mtrg_top`

## Requirements
- R1: With mode code 3'b000, `trg_out` equals the value that `ug_strobe` had one clock earlier.
- R2: With mode code 3'b001, `trg_out` equals the value that `cnt_en` had one clock earlier.
- R3: `cnt_en` is high whenever `sw_en` is high, or when both `gated_mode` and `trig_in` are high, and is low otherwise. It responds in the same cycle, with no register in the path.
- R4: With mode code 3'b010, `trg_out` equals the value that `update_evt` had one clock earlier.
- R5: With mode code 3'b011, `trg_out` is high for exactly one clock after each cycle in which `cc1_set` is high. Back-to-back match cycles give back-to-back pulses, even though the flag they set is already high.
- R6: With mode code 3'b100, `trg_out` follows the level of `oc1_ref` with one clock of latency.
- R7: With mode codes 3'b101, 3'b110 and 3'b111, `trg_out` is low one clock later, whatever the source inputs are.
- R8: While `rst_n` is low, `trg_out` is low.
- R9: A change of `mode` takes effect on the next clock edge. The value registered at that edge comes from the source that the new code selects.

Ports follow, in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Master-mode code that selects the trigger source |
| ug_strobe | input | 1 | Software update-generate strobe |
| sw_en | input | 1 | Software counter-enable bit |
| gated_mode | input | 1 | High while the slave controller is in gated mode |
| trig_in | input | 1 | Slave trigger input |
| update_evt | input | 1 | Counter update event |
| cc1_set | input | 1 | One-cycle pulse for each channel 1 capture/compare match |
| oc1_ref | input | 1 | Channel 1 output reference level |
| cnt_en | output | 1 | Combined counter-enable signal |
| trg_out | output | 1 | Registered trigger output to slave timers |

## Verification
Two things can happen in the same cycle: a mode change, and activity on both the old source and the new one. The bench switches `mode` on the same falling edge on which it raises one source and drops another. The registered result must match the newly selected source. The same holds when the gated trigger and the software enable change in the cycle in which mode 001 is selected, because `cnt_en` must then reach the trigger register with no extra cycle of delay.

// File: rtl/mtrg_pkg.sv
package mtrg_pkg;
    localparam int MODE_W  = 3;
    localparam int NUM_SRC = 5;

    // source slot indices, equal to the mode code that selects them
    localparam int SRC_UG   = 0;
    localparam int SRC_CEN  = 1;
    localparam int SRC_UPD  = 2;
    localparam int SRC_CCP  = 3;
    localparam int SRC_OREF = 4;

    typedef struct packed {
        logic trg;
    } trg_state_t;
endpackage

// File: rtl/mtrg_cen.sv
module mtrg_cen (
    input  logic sw_en,
    input  logic gated_mode,
    input  logic trig_in,
    output logic cnt_en
);
    logic gate_hit;

    always_comb begin
        gate_hit = gated_mode & trig_in;
        cnt_en   = sw_en | gate_hit;
    end
endmodule

// File: rtl/mtrg_sel.sv
module mtrg_sel #(
    parameter int MODE_W  = 3,
    parameter int NUM_SRC = 5
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [MODE_W-1:0]  mode,
    output logic               sel_out
);
    logic [NUM_SRC-1:0] hit;

    // one decoded lane per source; codes past NUM_SRC-1 hit nothing
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        assign hit[i] = (mode == MODE_W'(i)) & src[i];
    end

    assign sel_out = |hit;
endmodule

// File: rtl/mtrg_top.sv
module mtrg_top
    import mtrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              ug_strobe,
    input  logic              sw_en,
    input  logic              gated_mode,
    input  logic              trig_in,
    input  logic              update_evt,
    input  logic              cc1_set,
    input  logic              oc1_ref,
    output logic              cnt_en,
    output logic              trg_out
);
    logic [NUM_SRC-1:0] src_vec;
    logic               sel_out;
    trg_state_t         st_d, st_q;

    mtrg_cen i_cen (
        .sw_en      (sw_en),
        .gated_mode (gated_mode),
        .trig_in    (trig_in),
        .cnt_en     (cnt_en)
    );

    always_comb begin
        src_vec           = '0;
        src_vec[SRC_UG]   = ug_strobe;
        src_vec[SRC_CEN]  = cnt_en;
        src_vec[SRC_UPD]  = update_evt;
        src_vec[SRC_CCP]  = cc1_set;
        src_vec[SRC_OREF] = oc1_ref;
    end

    mtrg_sel #(
        .MODE_W  (MODE_W),
        .NUM_SRC (NUM_SRC)
    ) i_sel (
        .src     (src_vec),
        .mode    (mode),
        .sel_out (sel_out)
    );

    always_comb begin
        st_d     = st_q;
        st_d.trg = sel_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trg_out = st_q.trg;
endmodule

// File: rtl/mtrg_chk.sv
module mtrg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       ug_strobe,
    input logic       sw_en,
    input logic       gated_mode,
    input logic       trig_in,
    input logic       update_evt,
    input logic       cc1_set,
    input logic       oc1_ref,
    input logic       cnt_en,
    input logic       trg_out
);
    AST_UG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |=> (trg_out == $past(ug_strobe))); // R1
    AST_CEN_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |=> (trg_out == $past(cnt_en))); // R2
    AST_CEN_SW: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> cnt_en); // R3
    AST_CEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && !gated_mode) |-> !cnt_en); // R3
    AST_UPD_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |=> (trg_out == $past(update_evt))); // R4
    AST_CCP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && cc1_set) |=> trg_out); // R5
    AST_CCP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && !cc1_set) |=> !trg_out); // R5
    AST_OREF_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> (trg_out == $past(oc1_ref))); // R6
    AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > 3'd4) |=> !trg_out); // R7
endmodule

bind mtrg_top mtrg_chk i_mtrg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .ug_strobe  (ug_strobe),
    .sw_en      (sw_en),
    .gated_mode (gated_mode),
    .trig_in    (trig_in),
    .update_evt (update_evt),
    .cc1_set    (cc1_set),
    .oc1_ref    (oc1_ref),
    .cnt_en     (cnt_en),
    .trg_out    (trg_out)
);

// File: tb/test_mtrg_top.sv
module test_mtrg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       ug_strobe = 1'b0, sw_en = 1'b0, gated_mode = 1'b0, trig_in = 1'b0;
    logic       update_evt = 1'b0, cc1_set = 1'b0, oc1_ref = 1'b0;
    logic       cnt_en, trg_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk; // 250 MHz

    mtrg_top i_mtrg_top (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ug_strobe(ug_strobe),
        .sw_en(sw_en), .gated_mode(gated_mode), .trig_in(trig_in),
        .update_evt(update_evt), .cc1_set(cc1_set), .oc1_ref(oc1_ref),
        .cnt_en(cnt_en), .trg_out(trg_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus, pushes the expected trigger
    task automatic step(input logic [2:0] m, input logic ug, input logic en,
                        input logic gm, input logic ti, input logic up,
                        input logic cc, input logic oc, input string tag);
        logic cen_exp;
        logic trg_exp;
        sb_item_t it;
        @(negedge clk);
        mode = m; ug_strobe = ug; sw_en = en; gated_mode = gm; trig_in = ti;
        update_evt = up; cc1_set = cc; oc1_ref = oc;
        cen_exp = en | (gm & ti);
        case (m)
            3'd0:    trg_exp = ug;
            3'd1:    trg_exp = cen_exp;
            3'd2:    trg_exp = up;
            3'd3:    trg_exp = cc;
            3'd4:    trg_exp = oc;
            default: trg_exp = 1'b0;
        endcase
        it.exp = trg_exp;
        it.tag = tag;
        sb_q.push_back(it);
        #1;
        check(cnt_en, cen_exp, "R3 cnt_en");
    endtask

    // monitor: one registered result per clock after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(trg_out, it.exp, it.tag);
            end
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset holds the trigger low, even with every source high
        mode = 3'd4; oc1_ref = 1'b1; ug_strobe = 1'b1; update_evt = 1'b1;
        repeat (3) @(posedge clk);
        #1 check(trg_out, 1'b0, "R8 reset");
        @(negedge clk);
        mode = 3'd0; oc1_ref = 1'b0; ug_strobe = 1'b0; update_evt = 1'b0;
        rst_n = 1'b1;

        // R1 update-generate strobe
        step(3'd0, 1, 0, 0, 0, 0, 0, 0, "R1 ug high");
        step(3'd0, 0, 1, 0, 0, 1, 1, 1, "R1 ug low others high");
        step(3'd0, 1, 0, 0, 0, 0, 0, 0, "R1 ug again");

        // R2 and R3 counter enable combinations
        step(3'd1, 0, 1, 0, 0, 0, 0, 0, "R2 sw_en");
        step(3'd1, 0, 0, 0, 1, 0, 0, 0, "R2 trig not gated");
        step(3'd1, 0, 0, 1, 1, 0, 0, 0, "R2 gated trig");
        step(3'd1, 0, 0, 1, 0, 0, 0, 0, "R2 gated no trig");
        step(3'd1, 0, 1, 1, 1, 0, 0, 0, "R2 both");

        // R4 update event
        step(3'd2, 0, 0, 0, 0, 1, 0, 0, "R4 update");
        step(3'd2, 1, 1, 0, 0, 0, 1, 1, "R4 no update");

        // R5 compare pulse, including back-to-back matches
        step(3'd3, 0, 0, 0, 0, 0, 1, 0, "R5 match");
        step(3'd3, 0, 0, 0, 0, 0, 0, 1, "R5 gap");
        step(3'd3, 0, 0, 0, 0, 0, 1, 0, "R5 b2b first");
        step(3'd3, 0, 0, 0, 0, 0, 1, 0, "R5 b2b second");
        step(3'd3, 0, 0, 0, 0, 0, 0, 0, "R5 end");

        // R6 output reference level
        step(3'd4, 0, 0, 0, 0, 0, 0, 1, "R6 ref high");
        step(3'd4, 0, 0, 0, 0, 0, 0, 1, "R6 ref held");
        step(3'd4, 1, 1, 0, 0, 1, 1, 0, "R6 ref low");

        // R7 reserved codes with every source high
        for (int m = 5; m < 8; m++)
            step(3'(m), 1, 1, 1, 1, 1, 1, 1, "R7 reserved");

        // R9 mode switch in the same cycle as source activity
        step(3'd4, 0, 0, 0, 0, 0, 0, 1, "R9 before switch");
        step(3'd2, 0, 0, 0, 0, 1, 0, 0, "R9 switch to update");
        step(3'd0, 0, 0, 0, 0, 1, 0, 0, "R9 switch to ug");
        step(3'd1, 0, 0, 1, 1, 0, 0, 0, "R9 switch to gated cen");
        step(3'd3, 1, 1, 0, 0, 0, 0, 0, "R9 switch to ccp");
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule